// File: doc/BRIEF.md
# Configurable Majority Ladder Cell

This block is a two-operand logic cell whose Boolean function is set by a 3-bit control word rather than by a multiplexer or a lookup table. Three three-input majority voters are chained in series. The first voter sees both data operands and one control bit. The second voter sees the first result, a second control bit and the complement of operand `a`. The third voter sees the second result, the last control bit and the complement of operand `b`, and gives the output `y`. Holding a voter's control input at 0 turns it into an AND, and holding it at 1 turns it into an OR. The control word therefore picks functions such as NOR and NAND.

Each voter is one register stage, so a result appears three clocks after its inputs. A valid flag moves through the stages with the data. A split-operand mode replaces the two complement feeds with two separate operand ports, `x_op` and `y_op`. With `a` and `b` held at 0, this lets the later stages act directly as a two-input AND or OR. All data ports are `WIDTH` lanes wide. The lanes are independent bitwise copies of the cell, and they share one control word.

The design has no state machine. The only sequential behaviour is the three-stage pipeline, with stages named vote1, vote2 and vote3. Each stage reloads on every clock. There are no states or transitions to name.

Top module: `mjl_ladder`

## Requirements
- R1: For every lane and every control word, `y` equals maj(maj(maj(a, b, c1), c2, p), c3, q). Here maj is 1 when at least two of its inputs are 1. The control bits are mapped as c1 = `ctrl[2]`, c2 = `ctrl[1]` and c3 = `ctrl[0]`. In normal mode p = ~a and q = ~b.
- R2: `out_valid` equals the `in_valid` value sampled three clock edges earlier, and `y` at that point reflects the inputs sampled on that same edge.
- R3: With `ctrl` = 3'b010 and `split_en` = 0, `y` equals NOR(a, b) in every lane.
- R4: With `ctrl` = 3'b101 and `split_en` = 0, `y` equals NAND(a, b) in every lane.
- R5: With `split_en` = 1, p = `x_op` and q = `y_op`. With a = b = 0 and `ctrl` = 3'b010, `y` equals `x_op` AND `y_op`.
- R6: With `split_en` = 1, a = b = 0 and `ctrl` = 3'b011, `y` equals `x_op` OR `y_op`.
- R7: A synchronous active-high `rst` clears all stage registers and valid flags, so `y` = 0 and `out_valid` = 0 on the clock after reset is sampled.
- R8: Lanes are independent. Each bit of `y` depends only on the same bit of `a`, `b`, `x_op` and `y_op`.
- R9: A new input may be accepted on every clock. Results leave in order, one per clock, with no bubbles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inputs on this edge are meaningful |
| a | input | WIDTH | First data operand |
| b | input | WIDTH | Second data operand |
| ctrl | input | 3 | Control word {c1, c2, c3} |
| split_en | input | 1 | Use x_op/y_op instead of ~a/~b |
| x_op | input | WIDTH | Second-stage operand in split mode |
| y_op | input | WIDTH | Third-stage operand in split mode |
| out_valid | output | 1 | y holds a result |
| y | output | WIDTH | Cell output |

## Verification
Every result is due on the third rising edge after the edge that samples its inputs. The bench drives inputs at a falling edge, counts three rising edges, and reads `y` and `out_valid` at the next falling edge. It then lets one more edge pass to confirm that the valid flag drops. In the streaming test, the bench compares the output at each falling edge with the input it drove three cycles earlier, which checks both ordering and the absence of gaps. The reset check reads the outputs at the falling edge just after the first reset edge.

// File: rtl/mjl_pkg.sv
package mjl_pkg;
    // number of cascaded voter stages (clock zones)
    localparam int STAGES = 3;
    // control word bit positions: ctrl = {c1, c2, c3}
    localparam int C1_BIT = 2;
    localparam int C2_BIT = 1;
    localparam int C3_BIT = 0;
    // named control words
    localparam logic [2:0] FN_NOR  = 3'b010;
    localparam logic [2:0] FN_NAND = 3'b101;
    localparam logic [2:0] FN_XAND = 3'b010;
    localparam logic [2:0] FN_XOR_ = 3'b011;
endpackage

// File: rtl/mjl_delay.sv
module mjl_delay #(
    parameter int W     = 1,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (DEPTH == 0) begin : g_wire
            assign q = d;
        end else begin : g_shift
            logic [W-1:0] sr [DEPTH];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < DEPTH; i++) sr[i] <= '0;
                end else begin
                    sr[0] <= d;
                    for (int i = 1; i < DEPTH; i++) sr[i] <= sr[i-1];
                end
            end
            assign q = sr[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/mjl_vote_stage.sv
module mjl_vote_stage #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         vld_i,
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] opnd_i,
    input  logic         ctl_i,
    output logic         vld_o,
    output logic [W-1:0] acc_o
);
    logic [W-1:0] ctl_v;
    logic [W-1:0] vote_d;

    assign ctl_v  = {W{ctl_i}};
    assign vote_d = (acc_i & opnd_i) | (acc_i & ctl_v) | (opnd_i & ctl_v);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_o <= '0;
            vld_o <= 1'b0;
        end else begin
            acc_o <= vote_d;
            vld_o <= vld_i;
        end
    end
endmodule

// File: rtl/mjl_ladder.sv
module mjl_ladder
    import mjl_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [2:0]       ctrl,
    input  logic             split_en,
    input  logic [WIDTH-1:0] x_op,
    input  logic [WIDTH-1:0] y_op,
    output logic             out_valid,
    output logic [WIDTH-1:0] y
);
    // per-stage third operand and control bit, as seen at the input edge
    logic [WIDTH-1:0] opnd_raw [STAGES];
    logic             ctl_raw  [STAGES];
    // aligned to the stage that consumes them
    logic [WIDTH-1:0] opnd_al  [STAGES];
    logic             ctl_al   [STAGES];
    // chain of stage results
    logic [WIDTH-1:0] acc      [STAGES+1];
    logic             vld      [STAGES+1];

    assign opnd_raw[0] = b;
    assign opnd_raw[1] = split_en ? x_op : ~a;
    assign opnd_raw[2] = split_en ? y_op : ~b;
    assign ctl_raw[0]  = ctrl[C1_BIT];
    assign ctl_raw[1]  = ctrl[C2_BIT];
    assign ctl_raw[2]  = ctrl[C3_BIT];

    assign acc[0] = a;
    assign vld[0] = in_valid;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_zone
            mjl_delay #(.W(WIDTH + 1), .DEPTH(s)) u_align (
                .clk (clk),
                .rst (rst),
                .d   ({ctl_raw[s], opnd_raw[s]}),
                .q   ({ctl_al[s], opnd_al[s]})
            );
            mjl_vote_stage #(.W(WIDTH)) u_vote (
                .clk    (clk),
                .rst    (rst),
                .vld_i  (vld[s]),
                .acc_i  (acc[s]),
                .opnd_i (opnd_al[s]),
                .ctl_i  (ctl_al[s]),
                .vld_o  (vld[s+1]),
                .acc_o  (acc[s+1])
            );
        end
    endgenerate

    assign y         = acc[STAGES];
    assign out_valid = vld[STAGES];
endmodule

// File: rtl/mjl_ladder_chk.sv
module mjl_ladder_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic [2:0]       ctrl,
    input logic             split_en,
    input logic [WIDTH-1:0] x_op,
    input logic [WIDTH-1:0] y_op,
    input logic             out_valid,
    input logic [WIDTH-1:0] y
);
    // cycles since reset, saturating at 3, so $past(...,3) stays after reset
    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (rst) warm <= 2'd0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    // R2
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    // R3
    nor_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3 && $past(in_valid, 3) && !$past(split_en, 3) && $past(ctrl, 3) == 3'b010)
        |-> (y == ~($past(a, 3) | $past(b, 3))));

    // R4
    nand_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3 && $past(in_valid, 3) && !$past(split_en, 3) && $past(ctrl, 3) == 3'b101)
        |-> (y == ~($past(a, 3) & $past(b, 3))));

    // R5
    split_and_chk: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3 && $past(in_valid, 3) && $past(split_en, 3) && $past(ctrl, 3) == 3'b010
         && $past(a, 3) == '0 && $past(b, 3) == '0)
        |-> (y == ($past(x_op, 3) & $past(y_op, 3))));

    // R6
    split_or_chk: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3 && $past(in_valid, 3) && $past(split_en, 3) && $past(ctrl, 3) == 3'b011
         && $past(a, 3) == '0 && $past(b, 3) == '0)
        |-> (y == ($past(x_op, 3) | $past(y_op, 3))));

    // R7
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && y == '0));
endmodule

bind mjl_ladder mjl_ladder_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .a(a), .b(b), .ctrl(ctrl),
    .split_en(split_en), .x_op(x_op), .y_op(y_op), .out_valid(out_valid), .y(y)
);

// File: tb/mjl_ladder_tb.sv
`timescale 1ns/1ps
module mjl_ladder_tb;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [W-1:0] a = '0, b = '0, x_op = '0, y_op = '0;
    logic [2:0]   ctrl = '0;
    logic         split_en = 1'b0;
    logic         out_valid;
    logic [W-1:0] y;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    mjl_ladder #(.WIDTH(W)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .a(a), .b(b), .ctrl(ctrl),
        .split_en(split_en), .x_op(x_op), .y_op(y_op), .out_valid(out_valid), .y(y)
    );

    function automatic logic [W-1:0] maj(input logic [W-1:0] p, q, r);
        return (p & q) | (p & r) | (q & r);
    endfunction

    // spec evaluation of the ladder (R1)
    function automatic logic [W-1:0] spec(input logic [W-1:0] ia, ib, ix, iy,
                                          input logic [2:0] c, input logic sp);
        logic [W-1:0] s1, s2;
        s1 = maj(ia, ib, {W{c[2]}});
        s2 = maj(s1, {W{c[1]}}, sp ? ix : ~ia);
        return maj(s2, {W{c[0]}}, sp ? iy : ~ib);
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // drive one input, check it three edges later, then check valid drops
    task automatic one_shot(input string req, input logic [W-1:0] ia, ib, ix, iy,
                            input logic [2:0] c, input logic sp, input logic [W-1:0] exp);
        @(negedge clk);
        a = ia; b = ib; x_op = ix; y_op = iy; ctrl = c; split_en = sp; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(req, y, exp);
        check("R2 valid high", {{(W-1){1'b0}}, out_valid}, 1);
        @(posedge clk);
        @(negedge clk);
        check("R2 valid low", {{(W-1){1'b0}}, out_valid}, 0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R7 y", y, '0);
        check("R7 valid", {{(W-1){1'b0}}, out_valid}, 0);
        rst = 1'b0;
    endtask

    task automatic t_all_words();
        // lanes carry all four (a,b) combinations: lane i = {a,b} = i
        for (int c = 0; c < 8; c++)
            one_shot("R1 all words", 4'b1100, 4'b1010, '0, '0, c[2:0], 1'b0,
                     spec(4'b1100, 4'b1010, '0, '0, c[2:0], 1'b0));
    endtask

    task automatic t_nor();
        one_shot("R3 nor", 4'b1100, 4'b1010, '0, '0, 3'b010, 1'b0, 4'b0001);
    endtask

    task automatic t_nand();
        one_shot("R4 nand", 4'b1100, 4'b1010, '0, '0, 3'b101, 1'b0, 4'b0111);
    endtask

    task automatic t_split_and();
        one_shot("R5 split and", '0, '0, 4'b1100, 4'b1010, 3'b010, 1'b1, 4'b1000);
    endtask

    task automatic t_split_or();
        one_shot("R6 split or", '0, '0, 4'b1100, 4'b1010, 3'b011, 1'b1, 4'b1110);
    endtask

    task automatic t_lanes();
        // R8: one lane active per shot, NOR mode; others keep a=b=0 -> 1
        for (int l = 0; l < W; l++) begin
            logic [W-1:0] m;
            m = '0;
            m[l] = 1'b1;
            one_shot("R8 lane", m, '0, '0, '0, 3'b010, 1'b0, ~m);
        end
    endtask

    task automatic t_stream();
        logic [W-1:0] sa [4];
        logic [W-1:0] sb [4];
        logic [2:0]   sc [4];
        logic [W-1:0] ex [4];
        sa = '{4'b0011, 4'b1111, 4'b0101, 4'b1000};
        sb = '{4'b0110, 4'b0000, 4'b1100, 4'b1001};
        sc = '{3'b010, 3'b101, 3'b000, 3'b111};
        for (int i = 0; i < 4; i++) ex[i] = spec(sa[i], sb[i], '0, '0, sc[i], 1'b0);
        for (int k = 0; k < 7; k++) begin
            @(negedge clk);
            if (k >= 3) begin
                check("R9 stream data", y, ex[k-3]);
                check("R9 stream valid", {{(W-1){1'b0}}, out_valid}, 1);
            end
            if (k < 4) begin
                a = sa[k]; b = sb[k]; ctrl = sc[k]; split_en = 1'b0; in_valid = 1'b1;
            end else begin
                in_valid = 1'b0;
            end
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        t_reset();
        t_all_words();
        t_nor();
        t_nand();
        t_split_and();
        t_split_or();
        t_lanes();
        t_stream();
        // R7: reset mid-flight clears the pipeline
        @(negedge clk);
        a = 4'b0000; b = 4'b0000; ctrl = 3'b010; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R7 flushed valid", {{(W-1){1'b0}}, out_valid}, 0);
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule